// File: doc/BRIEF.md
# Dual-Address Operand Transfer Engine

This engine moves one operand per request between two memory-mapped locations. It first reads the operand from a source address and then writes it to a destination address. Each access goes over a plain single-master bus that has a cycle strobe, a write flag, an access size, an acknowledge and an error return. The access width on each side is set on its own, as byte, 16-bit word or 32-bit long-word. The operand takes the wider of the two. The engine gathers several narrow reads into a holding register, or spreads one wide read over several narrow writes.

A channel is set up with a load pulse that carries the two base addresses, a byte budget, the two access sizes and the two increment flags. Each rising request then moves one operand. The engine keeps the bus for the whole operand and ignores further requests while it does so. After a clean operand it reduces the budget and advances the addresses. The channel then waits for the next request, or it stops when the budget runs out or a peripheral has signalled completion. A bus error stops the channel at once. The engine reports which side failed.

Top module: `dmae_engine`

## Requirements
- R1: After reset the bus strobe `bus_cyc`, `armed` and all four result pulses are low.
- R2: When both sides use the same size, an operand takes exactly one read cycle and then one write cycle.
- R3: Size codes are 0 = byte, 1 = word, 2 or 3 = long-word. The operand size is the larger of the two sizes. An operand takes operand/source reads followed by operand/destination writes, with `bus_we` low for reads and high for writes, and `bus_size` carries the size of the side being accessed.
- R4: Data is right-justified in the 32-bit data buses. Reads fill the operand from the most significant byte down. Writes emit it most significant part first. Cycle k of a side uses that side's base address plus k times its access size. Address and direction stay stable while a cycle waits for an acknowledge.
- R5: From the first read until the last write is acknowledged, `bus_cyc` stays high. A request seen during an operand starts no extra operand.
- R6: `bus_err` wins over `bus_ack`. An error ends the operand, drops `bus_cyc` in the next cycle and disarms the channel. In that same cycle it pulses `src_err` for a read error or `dst_err` for a write error. The count and the addresses keep their values.
- R7: One cycle after the last write is acknowledged, `op_done` pulses. At that point the count has dropped by the operand size, saturating at 0. Each address has moved by the operand size if its increment flag is set, and is unchanged if the flag is clear.
- R8: If `done_in` is high in any bus cycle of an operand that then completes, the channel ends after that operand. `chan_end` pulses together with `op_done`, `armed` falls, and requests are ignored until the next load.
- R9: If the count before an operand is at most the operand size, the channel ends after that operand in the same way as R8.
- R10: A load is accepted only while `bus_cyc` is low. It arms the channel (`armed` high in the next cycle). A load during an operand changes no address, count or size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Load channel setup and arm |
| cfg_src_addr | input | AW | Source base address |
| cfg_dst_addr | input | AW | Destination base address |
| cfg_count | input | CW | Byte budget |
| cfg_src_size | input | 2 | Source access size code |
| cfg_dst_size | input | 2 | Destination access size code |
| cfg_src_inc | input | 1 | Advance source address per operand |
| cfg_dst_inc | input | 1 | Advance destination address per operand |
| req | input | 1 | Operand request |
| done_in | input | 1 | Peripheral end-of-channel signal |
| bus_cyc | output | 1 | Bus cycle active, bus held |
| bus_we | output | 1 | Write cycle |
| bus_addr | output | AW | Cycle address |
| bus_size | output | 2 | Cycle size code |
| bus_wdata | output | 32 | Write data, right-justified |
| bus_rdata | input | 32 | Read data, right-justified |
| bus_ack | input | 1 | Cycle acknowledge |
| bus_err | input | 1 | Cycle bus error |
| op_done | output | 1 | Operand completed pulse |
| chan_end | output | 1 | Channel ended normally pulse |
| src_err | output | 1 | Read-side bus error pulse |
| dst_err | output | 1 | Write-side bus error pulse |
| armed | output | 1 | Channel waiting for a request |
| cur_src_addr | output | AW | Current source base |
| cur_dst_addr | output | AW | Current destination base |
| cur_count | output | CW | Remaining byte budget |

## Verification
Two events can land on the same bus cycle. The first pair is the peripheral end signal and a bus error: the bench raises `done_in` on exactly the cycle it answers with an error. It expects the error pulse for that side, no `op_done` and no `chan_end`, and an unchanged count. The second pair is the end signal on the final write of an operand that also uses up the budget. There the bench expects a single `chan_end` together with `op_done`, and a disarmed channel that then ignores requests.

// File: rtl/dmae_pkg.sv
package dmae_pkg;
  localparam int DW = 32;
  localparam int NB = DW / 8;

  typedef enum logic [1:0] {ST_IDLE, ST_ARMED, ST_READ, ST_WRITE} dmae_state_t;

  function automatic logic [2:0] sz_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [DW-1:0] lane_mask(input logic [2:0] nb);
    case (nb)
      3'd1:    return 32'h0000_00FF;
      3'd2:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/dmae_ctrl.sv
module dmae_ctrl
  import dmae_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic        req,
  input  logic        done_in,
  input  logic        bus_ack,
  input  logic        bus_err,
  input  logic        rd_last,
  input  logic        wr_last,
  input  logic        cnt_last,
  output dmae_state_t state,
  output logic        load_ok,
  output logic        start,
  output logic        rd_step,
  output logic        wr_step,
  output logic        op_fin,
  output logic        op_done,
  output logic        chan_end,
  output logic        src_err,
  output logic        dst_err
);
  dmae_state_t state_n;
  logic done_seen, done_seen_n;
  logic in_rd, in_wr, hit, stop_now;

  always_comb begin
    in_rd    = (state == ST_READ);
    in_wr    = (state == ST_WRITE);
    hit      = bus_ack & ~bus_err;
    rd_step  = in_rd & hit;
    wr_step  = in_wr & hit;
    op_fin   = wr_step & wr_last;
    load_ok  = load & ~(in_rd | in_wr);
    start    = (state == ST_ARMED) & req;
    stop_now = cnt_last | done_seen | done_in;

    done_seen_n = done_seen;
    if (start)                        done_seen_n = 1'b0;
    else if ((in_rd | in_wr) && done_in) done_seen_n = 1'b1;

    state_n = state;
    case (state)
      ST_IDLE:  if (load_ok) state_n = ST_ARMED;
      ST_ARMED: if (start) state_n = ST_READ;
      ST_READ: begin
        if (bus_err)              state_n = ST_IDLE;
        else if (rd_step && rd_last) state_n = ST_WRITE;
      end
      ST_WRITE: begin
        if (bus_err)  state_n = ST_IDLE;
        else if (op_fin) state_n = stop_now ? ST_IDLE : ST_ARMED;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      done_seen <= 1'b0;
      op_done   <= 1'b0;
      chan_end  <= 1'b0;
      src_err   <= 1'b0;
      dst_err   <= 1'b0;
    end else begin
      state     <= state_n;
      done_seen <= done_seen_n;
      op_done   <= op_fin;
      chan_end  <= op_fin & stop_now;
      src_err   <= in_rd & bus_err;
      dst_err   <= in_wr & bus_err;
    end
  end
endmodule

// File: rtl/dmae_regs.sv
module dmae_regs
  import dmae_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_ok,
  input  logic [AW-1:0] cfg_src_addr,
  input  logic [AW-1:0] cfg_dst_addr,
  input  logic [CW-1:0] cfg_count,
  input  logic [1:0]    cfg_src_size,
  input  logic [1:0]    cfg_dst_size,
  input  logic          cfg_src_inc,
  input  logic          cfg_dst_inc,
  input  logic          op_fin,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr,
  output logic [CW-1:0] count,
  output logic [1:0]    src_sz,
  output logic [1:0]    dst_sz,
  output logic [2:0]    op_bytes,
  output logic          cnt_last
);
  logic          src_inc, dst_inc;
  logic [2:0]    sb, db;
  logic [CW-1:0] opb_w, count_n;
  logic [AW-1:0] opb_a, src_addr_n, dst_addr_n;

  always_comb begin
    sb       = sz_bytes(src_sz);
    db       = sz_bytes(dst_sz);
    op_bytes = (sb > db) ? sb : db;
    opb_w    = CW'(op_bytes);
    opb_a    = AW'(op_bytes);
    cnt_last = (count <= opb_w);
    count_n    = cnt_last ? '0 : (count - opb_w);
    src_addr_n = src_inc ? (src_addr + opb_a) : src_addr;
    dst_addr_n = dst_inc ? (dst_addr + opb_a) : dst_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_addr <= '0;
      dst_addr <= '0;
      count    <= '0;
      src_sz   <= 2'd0;
      dst_sz   <= 2'd0;
      src_inc  <= 1'b0;
      dst_inc  <= 1'b0;
    end else if (load_ok) begin
      src_addr <= cfg_src_addr;
      dst_addr <= cfg_dst_addr;
      count    <= cfg_count;
      src_sz   <= cfg_src_size;
      dst_sz   <= cfg_dst_size;
      src_inc  <= cfg_src_inc;
      dst_inc  <= cfg_dst_inc;
    end else if (op_fin) begin
      src_addr <= src_addr_n;
      dst_addr <= dst_addr_n;
      count    <= count_n;
    end
  end
endmodule

// File: rtl/dmae_pack.sv
module dmae_pack
  import dmae_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          rd_step,
  input  logic          wr_step,
  input  logic [1:0]    src_sz,
  input  logic [1:0]    dst_sz,
  input  logic [2:0]    op_bytes,
  input  logic [DW-1:0] rdata,
  output logic [DW-1:0] wdata,
  output logic [2:0]    rd_off,
  output logic [2:0]    wr_off,
  output logic          rd_last,
  output logic          wr_last
);
  logic [DW-1:0] hold, hold_n;
  logic [2:0]    rrem, wrem, rrem_n, wrem_n, sb, db, lag;
  logic [5:0]    shamt;

  always_comb begin
    sb      = sz_bytes(src_sz);
    db      = sz_bytes(dst_sz);
    rd_last = (rrem == sb);
    wr_last = (wrem == db);
    rd_off  = op_bytes - rrem;
    wr_off  = op_bytes - wrem;
    lag     = wrem - db;
    shamt   = {lag, 3'b000};
    wdata   = (hold >> shamt) & lane_mask(db);

    case (sb)
      3'd1:    hold_n = {hold[DW-9:0],  rdata[7:0]};
      3'd2:    hold_n = {hold[DW-17:0], rdata[15:0]};
      default: hold_n = rdata;
    endcase

    rrem_n = rrem;
    wrem_n = wrem;
    if (start) begin
      rrem_n = op_bytes;
      wrem_n = op_bytes;
    end else begin
      if (rd_step) rrem_n = rrem - sb;
      if (wr_step) wrem_n = wrem - db;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold <= '0;
      rrem <= 3'd0;
      wrem <= 3'd0;
    end else begin
      rrem <= rrem_n;
      wrem <= wrem_n;
      if (start)        hold <= '0;
      else if (rd_step) hold <= hold_n;
    end
  end
endmodule

// File: rtl/dmae_engine.sv
module dmae_engine
  import dmae_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] cfg_src_addr,
  input  logic [AW-1:0] cfg_dst_addr,
  input  logic [CW-1:0] cfg_count,
  input  logic [1:0]    cfg_src_size,
  input  logic [1:0]    cfg_dst_size,
  input  logic          cfg_src_inc,
  input  logic          cfg_dst_inc,
  input  logic          req,
  input  logic          done_in,
  output logic          bus_cyc,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [1:0]    bus_size,
  output logic [31:0]   bus_wdata,
  input  logic [31:0]   bus_rdata,
  input  logic          bus_ack,
  input  logic          bus_err,
  output logic          op_done,
  output logic          chan_end,
  output logic          src_err,
  output logic          dst_err,
  output logic          armed,
  output logic [AW-1:0] cur_src_addr,
  output logic [AW-1:0] cur_dst_addr,
  output logic [CW-1:0] cur_count
);
  dmae_state_t state;
  logic        load_ok, start, rd_step, wr_step, op_fin;
  logic        rd_last, wr_last, cnt_last;
  logic [1:0]  src_sz, dst_sz;
  logic [2:0]  op_bytes, rd_off, wr_off;

  dmae_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .load(load), .req(req), .done_in(done_in),
    .bus_ack(bus_ack), .bus_err(bus_err), .rd_last(rd_last), .wr_last(wr_last),
    .cnt_last(cnt_last), .state(state), .load_ok(load_ok), .start(start),
    .rd_step(rd_step), .wr_step(wr_step), .op_fin(op_fin), .op_done(op_done),
    .chan_end(chan_end), .src_err(src_err), .dst_err(dst_err)
  );

  dmae_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n), .load_ok(load_ok),
    .cfg_src_addr(cfg_src_addr), .cfg_dst_addr(cfg_dst_addr), .cfg_count(cfg_count),
    .cfg_src_size(cfg_src_size), .cfg_dst_size(cfg_dst_size),
    .cfg_src_inc(cfg_src_inc), .cfg_dst_inc(cfg_dst_inc), .op_fin(op_fin),
    .src_addr(cur_src_addr), .dst_addr(cur_dst_addr), .count(cur_count),
    .src_sz(src_sz), .dst_sz(dst_sz), .op_bytes(op_bytes), .cnt_last(cnt_last)
  );

  dmae_pack u_pack (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_step(rd_step), .wr_step(wr_step),
    .src_sz(src_sz), .dst_sz(dst_sz), .op_bytes(op_bytes), .rdata(bus_rdata),
    .wdata(bus_wdata), .rd_off(rd_off), .wr_off(wr_off),
    .rd_last(rd_last), .wr_last(wr_last)
  );

  always_comb begin
    bus_we   = (state == ST_WRITE);
    bus_cyc  = (state == ST_READ) | bus_we;
    armed    = (state == ST_ARMED);
    bus_size = bus_we ? dst_sz : src_sz;
    bus_addr = bus_we ? (cur_dst_addr + AW'(wr_off)) : (cur_src_addr + AW'(rd_off));
  end
endmodule

// File: rtl/dmae_checker.sv
module dmae_checker #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_cyc,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic          bus_ack,
  input logic          bus_err,
  input logic          op_done,
  input logic          chan_end,
  input logic          src_err,
  input logic          dst_err,
  input logic [AW-1:0] cur_src_addr,
  input logic [AW-1:0] cur_dst_addr,
  input logic [CW-1:0] cur_count
);
  AST_BUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && !bus_err && !(bus_we && bus_ack)) |=> bus_cyc); // R5

  AST_WAIT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && !bus_ack && !bus_err) |=> ($stable(bus_addr) && $stable(bus_we))); // R4

  AST_ERR_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && bus_err) |=> (!bus_cyc && (src_err != dst_err))); // R6

  AST_ERR_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && bus_err && !bus_we) |=> src_err); // R6

  AST_ERR_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (src_err || dst_err) |-> ($stable(cur_count) && $stable(cur_src_addr) && $stable(cur_dst_addr))); // R6

  AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |-> $past(bus_cyc && bus_we && bus_ack && !bus_err)); // R7

  AST_COUNT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |-> ((cur_count < $past(cur_count)) || ($past(cur_count) == '0))); // R7

  AST_END_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    chan_end |-> op_done); // R8

  AST_LOAD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && !bus_ack && !bus_err) |=> ($stable(cur_src_addr) && $stable(cur_count))); // R10
endmodule

bind dmae_engine dmae_checker #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_cyc(bus_cyc), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_ack(bus_ack), .bus_err(bus_err), .op_done(op_done), .chan_end(chan_end),
  .src_err(src_err), .dst_err(dst_err), .cur_src_addr(cur_src_addr),
  .cur_dst_addr(cur_dst_addr), .cur_count(cur_count)
);

// File: tb/dmae_engine_test.sv
module dmae_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int CW = 16;

  logic          clk, rst_n, load, req, done_in;
  logic [AW-1:0] cfg_src_addr, cfg_dst_addr;
  logic [CW-1:0] cfg_count;
  logic [1:0]    cfg_src_size, cfg_dst_size;
  logic          cfg_src_inc, cfg_dst_inc;
  logic          bus_cyc, bus_we, bus_ack, bus_err;
  logic [AW-1:0] bus_addr;
  logic [1:0]    bus_size;
  logic [31:0]   bus_wdata, bus_rdata;
  logic          op_done, chan_end, src_err, dst_err, armed;
  logic [AW-1:0] cur_src_addr, cur_dst_addr;
  logic [CW-1:0] cur_count;

  int tests = 0, fails = 0;
  logic [31:0] esa, eda;
  int ecnt, ess, eds, eis, eid;

  dmae_engine #(.AW(AW), .CW(CW)) uut (.*);

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int nbytes(input int sz);
    return (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
  endfunction

  function automatic logic [7:0] mb(input logic [31:0] a);
    return (a[7:0] * 8'd7) ^ a[15:8] ^ 8'h3C;
  endfunction

  function automatic logic [31:0] seg(input logic [31:0] base, input int st, input int n);
    logic [31:0] v = '0;
    for (int i = 0; i < n; i++) v = {v[23:0], mb(base + 32'(st + i))};
    return v;
  endfunction

  task automatic do_load(input logic [31:0] sa, input logic [31:0] da, input int cnt,
                         input int ss, input int ds, input int is, input int id);
    @(negedge clk);
    load = 1'b1; cfg_src_addr = sa; cfg_dst_addr = da; cfg_count = CW'(cnt);
    cfg_src_size = 2'(ss); cfg_dst_size = 2'(ds); cfg_src_inc = is[0]; cfg_dst_inc = id[0];
    @(negedge clk);
    load = 1'b0;
    esa = sa; eda = da; ecnt = cnt; ess = ss; eds = ds; eis = is; eid = id;
    chk("R10 armed after load", armed, 1);
  endtask

  // err_k/done_k/wait_k: bus cycle index within the operand, -1 for none
  task automatic do_op(input int err_k, input int done_k, input int wait_k, input bit load_mid);
    int sb, db, ob, nr, nw;
    bit ended;
    sb = nbytes(ess); db = nbytes(eds); ob = (sb > db) ? sb : db;
    nr = ob / sb; nw = ob / db;
    @(negedge clk); req = 1'b1;
    @(negedge clk);
    chk("R5 bus held at start", bus_cyc, 1);
    if (load_mid) begin
      load = 1'b1; cfg_src_addr = 32'hDEAD_0000; cfg_dst_addr = 32'hBEEF_0000;
      cfg_count = 16'd3; cfg_src_size = 2'd0; cfg_dst_size = 2'd0;
    end
    for (int k = 0; k < nr + nw; k++) begin
      logic [31:0] ea;
      bit rd;
      rd = (k < nr);
      ea = rd ? esa + 32'(k * sb) : eda + 32'((k - nr) * db);
      if (k == wait_k) begin
        bus_ack = 1'b0; bus_err = 1'b0;
        @(negedge clk);
        chk("R4 address held in wait", bus_addr, ea);
        chk("R5 bus held in wait", bus_cyc, 1);
      end
      chk("R3 direction", bus_we, !rd);
      chk("R3 size code", bus_size, rd ? ess : eds);
      chk("R4 address", bus_addr, ea);
      if (!rd) chk("R4 write data", bus_wdata, seg(esa, (k - nr) * db, db));
      bus_rdata = rd ? seg(esa, k * sb, sb) : 32'h0;
      bus_err = (k == err_k);
      bus_ack = 1'b1;
      done_in = (k == done_k);
      @(negedge clk);
      bus_ack = 1'b0; bus_err = 1'b0; done_in = 1'b0; req = 1'b0; load = 1'b0;
      if (k == err_k) begin
        chk("R6 src_err pulse", src_err, rd);
        chk("R6 dst_err pulse", dst_err, !rd);
        chk("R6 bus released", bus_cyc, 0);
        chk("R6 disarmed", armed, 0);
        chk("R6 no op_done", op_done, 0);
        chk("R6 no chan_end", chan_end, 0);
        chk("R6 count kept", cur_count, 64'(ecnt));
        chk("R6 src addr kept", cur_src_addr, esa);
        chk("R6 dst addr kept", cur_dst_addr, eda);
        return;
      end
      if (k < nr + nw - 1) begin
        chk("R5 bus held mid-operand", bus_cyc, 1);
        chk("R7 no early op_done", op_done, 0);
      end
    end
    ended = (ecnt <= ob) || (done_k >= 0);
    chk("R7 op_done pulse", op_done, 1);
    chk("R5 bus released at end", bus_cyc, 0);
    chk(ended ? "R9 R8 chan_end" : "R8 no chan_end", chan_end, ended);
    chk("R8 armed after operand", armed, !ended);
    ecnt = (ecnt > ob) ? ecnt - ob : 0;
    if (eis != 0) esa = esa + 32'(ob);
    if (eid != 0) eda = eda + 32'(ob);
    chk("R7 count", cur_count, 64'(ecnt));
    chk("R7 src addr", cur_src_addr, esa);
    chk("R7 dst addr", cur_dst_addr, eda);
    @(negedge clk);
    chk("R7 op_done one cycle", op_done, 0);
  endtask

  task automatic chk_idle_req(input string tag);
    @(negedge clk); req = 1'b1;
    @(negedge clk);
    chk(tag, bus_cyc, 0);
    @(negedge clk); req = 1'b0;
    chk(tag, bus_cyc, 0);
  endtask

  initial begin
    rst_n = 1'b0; load = 1'b0; req = 1'b0; done_in = 1'b0;
    bus_ack = 1'b0; bus_err = 1'b0; bus_rdata = '0;
    cfg_src_addr = '0; cfg_dst_addr = '0; cfg_count = '0;
    cfg_src_size = '0; cfg_dst_size = '0; cfg_src_inc = 1'b0; cfg_dst_inc = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 bus_cyc", bus_cyc, 0);
    chk("R1 armed", armed, 0);
    chk("R1 pulses", {op_done, chan_end, src_err, dst_err}, 0);

    // R2 R3 R4 R7: all size pairs and increment patterns
    for (int ss = 0; ss < 3; ss++)
      for (int ds = 0; ds < 3; ds++)
        for (int ip = 0; ip < 4; ip++) begin
          do_load(32'h0000_1000 + 32'(ss * 256 + ds * 64 + ip * 8), 32'h0000_8000 + 32'(ip * 16),
                  1000, ss, ds, ip & 1, (ip >> 1) & 1);
          do_op(-1, -1, -1, 1'b0);
          do_op(-1, -1, 1, ip == 3);
        end

    // size code 3 behaves as long-word (R3)
    do_load(32'h0000_2000, 32'h0000_3000, 100, 3, 0, 1, 1);
    do_op(-1, -1, -1, 1'b0);

    // R6: error on every bus cycle index for every size pair
    for (int ss = 0; ss < 3; ss++)
      for (int ds = 0; ds < 3; ds++) begin
        int sb2, db2, ob2;
        sb2 = nbytes(ss); db2 = nbytes(ds); ob2 = (sb2 > db2) ? sb2 : db2;
        for (int e = 0; e < ob2 / sb2 + ob2 / db2; e++) begin
          do_load(32'h0000_4000 + 32'(e), 32'h0000_5000, 50, ss, ds, 1, 1);
          do_op(e, -1, -1, 1'b0);
          chk_idle_req("R6 request ignored after error");
        end
      end

    // R8: done_in on each cycle of a long to byte operand
    for (int d = 0; d < 5; d++) begin
      do_load(32'h0000_6000, 32'h0000_7000, 200, 2, 0, 1, 0);
      do_op(-1, d, -1, 1'b0);
      chk_idle_req("R8 request ignored after end");
    end

    // R8 with R6 in the same cycle: error wins
    do_load(32'h0000_6100, 32'h0000_7100, 200, 0, 2, 1, 1);
    do_op(3, 3, -1, 1'b0);
    chk_idle_req("R6 R8 request ignored after error");

    // R9: budget exhaustion, word to word, count 5
    do_load(32'h0000_9000, 32'h0000_A000, 5, 1, 1, 1, 1);
    do_op(-1, -1, -1, 1'b0);
    do_op(-1, -1, -1, 1'b0);
    do_op(-1, -1, -1, 1'b0);
    chk_idle_req("R9 request ignored after exhaustion");

    // R9 with R8: done on last write when budget also ends
    do_load(32'h0000_B000, 32'h0000_C000, 4, 2, 2, 1, 1);
    do_op(-1, 1, -1, 1'b0);

    // R9: zero budget ends after first operand
    do_load(32'h0000_D000, 32'h0000_E000, 0, 0, 1, 0, 1);
    do_op(-1, -1, -1, 1'b0);
    chk_idle_req("R9 request ignored after zero budget");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule